// File: doc/BRIEF.md
# Byte-Addressed Direct-Mapped Cache with Run-Time Write Policies

This block is a four-line, 32-byte direct-mapped cache that sits between a single requester and a byte-wide main memory. The requester issues one-byte reads and writes over an 8-bit address. Each accepted access is classified as a hit or a miss and gets a response. Reads return the byte, and writes are completed according to two configuration pins. One pin chooses the write-hit policy: write-back, or write-through. The other chooses the write-miss policy: allocate, or bypass to memory.

The request side is a valid/ready interface. `req_ready` is high only while the cache is idle and no flush is being asserted. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. The request fields need only be valid in that cycle. The response is a one-cycle `rsp_valid` pulse and cannot be back-pressured.

The memory side is also valid/ready, one byte per transfer. Once `mem_valid` is raised, it stays high with its address, direction and write data frozen until a cycle where `mem_ready` is high. Read data on `mem_rdata` is taken in that same cycle. Two counters report accepted accesses and hits, so the hit rate is hits/accesses and the miss rate is 1 − hit rate.

Top module: `dm_cache`

## Requirements
- R1: The address is split into tag = addr[7:5], line index = addr[4:3] and byte offset = addr[2:0]. An access hits (`rsp_hit`=1) exactly when the indexed line is valid and its stored tag equals the address tag.
- R2: A read miss fills the indexed line with the whole 8-byte block, reading memory at offsets 0 to 7 in ascending order. After the fill, the read responds with the byte at the address. Every read returns the most recently written value of that byte.
- R3: With `cfg_write_back`=1, a write that lands in the cache changes only the cache and marks the line dirty. Memory receives the line only when it is evicted. A dirty victim is written back as 8 bytes, offsets 0 to 7, before the refill starts.
- R4: With `cfg_write_back`=0, every write also stores its byte to memory before the response is given.
- R5: With `cfg_write_alloc`=1, a write miss first fills the block, as in R2, and then writes the byte into the line. The line is then resident, so a later access to that block hits.
- R6: With `cfg_write_alloc`=0, a write miss stores the byte straight to memory and leaves the cache contents and tags unchanged.
- R7: `flush` sampled high while idle invalidates every line and discards dirty data. `req_ready` is low in any cycle where `flush` is high, so a flush takes priority over a request in the same cycle.
- R8: `stat_accesses` increments once for each accepted request. `stat_hits` increments once for each accepted request that is classified as a hit.
- R9: `req_ready` stays low from the acceptance of a miss or write-through access until its response. While `mem_valid` is high without `mem_ready`, the memory request fields hold steady.
- R10: A read hit, and a write hit in write-back mode, respond in the cycle right after acceptance. Every accepted request produces exactly one `rsp_valid` pulse.
- R11: After reset, all lines are invalid, both counters are zero, `req_ready` is high, and `rsp_valid` and `mem_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_write_back | input | 1 | 1 = write-back, 0 = write-through on write hits |
| cfg_write_alloc | input | 1 | 1 = allocate on write miss, 0 = write around |
| flush | input | 1 | Invalidate all lines while idle |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Cache can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_hit | output | 1 | Access was a hit |
| rsp_rdata | output | 8 | Read byte (zero for writes) |
| mem_valid | output | 1 | Memory transfer request |
| mem_ready | input | 1 | Memory accepts/completes the transfer |
| mem_write | output | 1 | 1 = store to memory, 0 = load |
| mem_addr | output | 8 | Memory byte address |
| mem_wdata | output | 8 | Byte stored to memory |
| mem_rdata | input | 8 | Byte loaded from memory, valid with `mem_ready` |
| stat_hits | output | 16 | Hit count |
| stat_accesses | output | 16 | Accepted access count |

## Verification
A wrong tag, valid or dirty bit does not show up at once. It surfaces at the next access to the affected line, either as a wrong `rsp_hit` on that response or as a stale byte on `rsp_rdata`. A dirty bit that is missed or spurious corrupts memory only when the line is evicted. For that reason, the full contents of memory are compared with an independent model after every response, so the error is caught on the access that evicts the line. Counter errors stay invisible until the counters are read, and they are compared at the end of the run.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EVICT,
    ST_FILL,
    ST_APPLY,
    ST_THRU
  } dmc_state_e;
endpackage

// File: rtl/dmc_meta.sv
module dmc_meta #(
  parameter int NUM_LINES = 4,
  parameter int TAG_W     = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clear_i,
  input  logic [$clog2(NUM_LINES)-1:0] lk_idx_i,
  input  logic [TAG_W-1:0]             lk_tag_i,
  output logic                         lk_hit_o,
  output logic                         lk_dirty_o,
  output logic [TAG_W-1:0]             lk_tag_o,
  input  logic                         inst_i,
  input  logic [$clog2(NUM_LINES)-1:0] inst_idx_i,
  input  logic [TAG_W-1:0]             inst_tag_i,
  input  logic                         mark_i,
  input  logic [$clog2(NUM_LINES)-1:0] mark_idx_i
);
  localparam int IDX_W = $clog2(NUM_LINES);

  logic [NUM_LINES-1:0] valid_q;
  logic [NUM_LINES-1:0] dirty_q;
  logic [TAG_W-1:0]     tag_q [NUM_LINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
      for (int i = 0; i < NUM_LINES; i++) tag_q[i] <= '0;
    end else if (clear_i) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      for (int i = 0; i < NUM_LINES; i++) begin
        if (inst_i && inst_idx_i == IDX_W'(i)) begin
          valid_q[i] <= 1'b1;
          dirty_q[i] <= 1'b0;
          tag_q[i]   <= inst_tag_i;
        end else if (mark_i && mark_idx_i == IDX_W'(i)) begin
          dirty_q[i] <= 1'b1;
        end
      end
    end
  end

  assign lk_hit_o   = valid_q[lk_idx_i] && (tag_q[lk_idx_i] == lk_tag_i);
  assign lk_dirty_o = valid_q[lk_idx_i] && dirty_q[lk_idx_i];
  assign lk_tag_o   = tag_q[lk_idx_i];

  // R7: a flush leaves no valid line behind
  p_flush_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (valid_q == '0));

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line_chk
    // R3: only a resident line can carry unwritten data
    p_dirty_resident_r3: assert property (@(posedge clk) disable iff (!rst_n)
      dirty_q[g] |-> valid_q[g]);
  end
endmodule

// File: rtl/dmc_data.sv
module dmc_data #(
  parameter int NUM_LINES  = 4,
  parameter int LINE_BYTES = 8,
  parameter int DATA_W     = 8
) (
  input  logic                          clk,
  input  logic                          we_i,
  input  logic [$clog2(NUM_LINES)-1:0]  w_idx_i,
  input  logic [$clog2(LINE_BYTES)-1:0] w_off_i,
  input  logic [DATA_W-1:0]             w_data_i,
  input  logic [$clog2(NUM_LINES)-1:0]  a_idx_i,
  input  logic [$clog2(LINE_BYTES)-1:0] a_off_i,
  output logic [DATA_W-1:0]             a_data_o,
  input  logic [$clog2(NUM_LINES)-1:0]  b_idx_i,
  input  logic [$clog2(LINE_BYTES)-1:0] b_off_i,
  output logic [DATA_W-1:0]             b_data_o
);
  localparam int DEPTH = NUM_LINES * LINE_BYTES;

  logic [DATA_W-1:0] bytes_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) bytes_q[{w_idx_i, w_off_i}] <= w_data_i;
  end

  assign a_data_o = bytes_q[{a_idx_i, a_off_i}];
  assign b_data_o = bytes_q[{b_idx_i, b_off_i}];
endmodule

// File: rtl/dmc_stats.sv
module dmc_stats #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_i,
  input  logic             hit_i,
  output logic [CNT_W-1:0] acc_o,
  output logic [CNT_W-1:0] hits_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_o  <= '0;
      hits_o <= '0;
    end else if (acc_i) begin
      acc_o <= acc_o + 1'b1;
      if (hit_i) hits_o <= hits_o + 1'b1;
    end
  end

  // R8: the hit count never moves without the access count
  p_hit_with_access_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(hits_o) |-> !$stable(acc_o));
endmodule

// File: rtl/dm_cache.sv
module dm_cache #(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int LINE_BYTES = 8,
  parameter int NUM_LINES  = 4,
  parameter int CNT_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_write_back,
  input  logic              cfg_write_alloc,
  input  logic              flush,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [CNT_W-1:0]  stat_hits,
  output logic [CNT_W-1:0]  stat_accesses
);
  import dmc_pkg::*;

  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int IDX_W = $clog2(NUM_LINES);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

  dmc_state_e        st_q, st_d;
  logic [OFF_W-1:0]  beat_q, beat_d;
  logic [TAG_W-1:0]  vtag_q, vtag_d;
  logic [ADDR_W-1:0] q_addr;
  logic [DATA_W-1:0] q_wdata;
  logic              q_we, q_hit, q_wb;

  logic              rsp_v_d, rsp_h_d;
  logic [DATA_W-1:0] rsp_r_d;

  logic [ADDR_W-1:0] lk_addr;
  logic [IDX_W-1:0]  lk_idx, q_idx;
  logic [TAG_W-1:0]  lk_tag, q_tag, lk_tag_o;
  logic [OFF_W-1:0]  lk_off, q_off;
  logic              lk_hit, lk_dirty;

  logic              dw_en;
  logic [IDX_W-1:0]  dw_idx;
  logic [OFF_W-1:0]  dw_off;
  logic [DATA_W-1:0] dw_data;
  logic [DATA_W-1:0] rd_a, rd_b;
  logic              inst, mark, acc, accept, clear;
  logic [IDX_W-1:0]  mark_idx;

  assign req_ready = (st_q == ST_IDLE) && !flush;
  assign accept    = req_valid && req_ready;
  assign clear     = flush && (st_q == ST_IDLE);

  assign lk_addr = (st_q == ST_IDLE) ? req_addr : q_addr;
  assign lk_idx  = lk_addr[OFF_W +: IDX_W];
  assign lk_tag  = lk_addr[ADDR_W-1 -: TAG_W];
  assign lk_off  = lk_addr[OFF_W-1:0];
  assign q_idx   = q_addr[OFF_W +: IDX_W];
  assign q_tag   = q_addr[ADDR_W-1 -: TAG_W];
  assign q_off   = q_addr[OFF_W-1:0];

  dmc_meta #(.NUM_LINES(NUM_LINES), .TAG_W(TAG_W)) u_meta (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (clear),
    .lk_idx_i   (lk_idx),
    .lk_tag_i   (lk_tag),
    .lk_hit_o   (lk_hit),
    .lk_dirty_o (lk_dirty),
    .lk_tag_o   (lk_tag_o),
    .inst_i     (inst),
    .inst_idx_i (q_idx),
    .inst_tag_i (q_tag),
    .mark_i     (mark),
    .mark_idx_i (mark_idx)
  );

  dmc_data #(.NUM_LINES(NUM_LINES), .LINE_BYTES(LINE_BYTES), .DATA_W(DATA_W)) u_data (
    .clk      (clk),
    .we_i     (dw_en),
    .w_idx_i  (dw_idx),
    .w_off_i  (dw_off),
    .w_data_i (dw_data),
    .a_idx_i  (lk_idx),
    .a_off_i  (lk_off),
    .a_data_o (rd_a),
    .b_idx_i  (q_idx),
    .b_off_i  (beat_q),
    .b_data_o (rd_b)
  );

  dmc_stats #(.CNT_W(CNT_W)) u_stats (
    .clk    (clk),
    .rst_n  (rst_n),
    .acc_i  (acc),
    .hit_i  (lk_hit),
    .acc_o  (stat_accesses),
    .hits_o (stat_hits)
  );

  always_comb begin
    st_d      = st_q;
    beat_d    = beat_q;
    vtag_d    = vtag_q;
    rsp_v_d   = 1'b0;
    rsp_h_d   = rsp_hit;
    rsp_r_d   = rsp_rdata;
    dw_en     = 1'b0;
    dw_idx    = q_idx;
    dw_off    = q_off;
    dw_data   = q_wdata;
    inst      = 1'b0;
    mark      = 1'b0;
    mark_idx  = q_idx;
    mem_valid = 1'b0;
    mem_write = 1'b0;
    mem_addr  = q_addr;
    mem_wdata = q_wdata;
    acc       = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          acc = 1'b1;
          if (lk_hit) begin
            if (!req_write) begin
              rsp_v_d = 1'b1;
              rsp_h_d = 1'b1;
              rsp_r_d = rd_a;
            end else begin
              dw_en   = 1'b1;
              dw_idx  = lk_idx;
              dw_off  = lk_off;
              dw_data = req_wdata;
              if (cfg_write_back) begin
                mark     = 1'b1;
                mark_idx = lk_idx;
                rsp_v_d  = 1'b1;
                rsp_h_d  = 1'b1;
                rsp_r_d  = '0;
              end else begin
                st_d = ST_THRU;
              end
            end
          end else if (req_write && !cfg_write_alloc) begin
            st_d = ST_THRU;
          end else begin
            beat_d = '0;
            vtag_d = lk_tag_o;
            st_d   = lk_dirty ? ST_EVICT : ST_FILL;
          end
        end
      end
      ST_EVICT: begin
        mem_valid = 1'b1;
        mem_write = 1'b1;
        mem_addr  = {vtag_q, q_idx, beat_q};
        mem_wdata = rd_b;
        if (mem_ready) begin
          beat_d = beat_q + 1'b1;
          if (&beat_q) st_d = ST_FILL;
        end
      end
      ST_FILL: begin
        mem_valid = 1'b1;
        mem_addr  = {q_tag, q_idx, beat_q};
        if (mem_ready) begin
          dw_en   = 1'b1;
          dw_off  = beat_q;
          dw_data = mem_rdata;
          beat_d  = beat_q + 1'b1;
          if (&beat_q) begin
            inst = 1'b1;
            st_d = ST_APPLY;
          end
        end
      end
      ST_APPLY: begin
        if (!q_we) begin
          rsp_v_d = 1'b1;
          rsp_h_d = q_hit;
          rsp_r_d = rd_a;
          st_d    = ST_IDLE;
        end else begin
          dw_en = 1'b1;
          if (q_wb) begin
            mark    = 1'b1;
            rsp_v_d = 1'b1;
            rsp_h_d = q_hit;
            rsp_r_d = '0;
            st_d    = ST_IDLE;
          end else begin
            st_d = ST_THRU;
          end
        end
      end
      ST_THRU: begin
        mem_valid = 1'b1;
        mem_write = 1'b1;
        if (mem_ready) begin
          rsp_v_d = 1'b1;
          rsp_h_d = q_hit;
          rsp_r_d = '0;
          st_d    = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      beat_q    <= '0;
      vtag_q    <= '0;
      q_addr    <= '0;
      q_wdata   <= '0;
      q_we      <= 1'b0;
      q_hit     <= 1'b0;
      q_wb      <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      st_q      <= st_d;
      beat_q    <= beat_d;
      vtag_q    <= vtag_d;
      rsp_valid <= rsp_v_d;
      rsp_hit   <= rsp_h_d;
      rsp_rdata <= rsp_r_d;
      if (accept) begin
        q_addr  <= req_addr;
        q_wdata <= req_wdata;
        q_we    <= req_write;
        q_hit   <= lk_hit;
        q_wb    <= cfg_write_back;
      end
    end
  end

  // R9: no new request is taken while memory traffic is outstanding
  p_busy_blocks_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !req_ready);

  // R9: a stalled memory request keeps its fields
  p_mem_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) &&
                                   $stable(mem_write) && $stable(mem_wdata)));

  // R10: a response only follows an accepted request or finished work
  p_rsp_has_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(accept) || $past(st_q) != ST_IDLE));
endmodule

// File: tb/dm_cache_bench.sv
module dm_cache_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wb = 1'b1, cfg_al = 1'b1, flush = 1'b0;
  logic       req_valid = 1'b0, req_write = 1'b0;
  logic [7:0] req_addr = '0, req_wdata = '0;
  logic       req_ready, rsp_valid, rsp_hit;
  logic [7:0] rsp_rdata;
  logic       mem_valid, mem_write;
  logic       mem_ready = 1'b0;
  logic [7:0] mem_addr, mem_wdata, mem_rdata;
  logic [15:0] stat_hits, stat_accesses;

  int nchk = 0, nfail = 0, exp_acc = 0, exp_hits = 0;
  bit done = 1'b0;

  logic [7:0] pmem [256];
  logic [7:0] m_mem [256];
  logic [7:0] mc [32];
  logic [2:0] mt [4];
  bit         mv [4];
  bit         md [4];

  always #5 clk = ~clk;

  dm_cache u_dm_cache (
    .clk(clk), .rst_n(rst_n), .cfg_write_back(cfg_wb), .cfg_write_alloc(cfg_al),
    .flush(flush), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_rdata(rsp_rdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .stat_hits(stat_hits), .stat_accesses(stat_accesses)
  );

  assign mem_rdata = pmem[mem_addr];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) pmem[i] <= 8'(i * 7 + 3);
    end else if (mem_valid && mem_ready && mem_write) begin
      pmem[mem_addr] <= mem_wdata;
    end
  end

  always @(negedge clk) mem_ready <= mem_valid && (($urandom % 3) != 0);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string mem_req_tag();
    if (!cfg_al) return "R6";
    return cfg_wb ? "R3" : "R4";
  endfunction

  task automatic model_evict_fill(input logic [7:0] a);
    logic [1:0] ix = a[4:3];
    if (mv[ix] && md[ix])
      for (int k = 0; k < 8; k++) m_mem[{mt[ix], ix, 3'(k)}] = mc[{ix, 3'(k)}];
    for (int k = 0; k < 8; k++) mc[{ix, 3'(k)}] = m_mem[{a[7:5], ix, 3'(k)}];
    mv[ix] = 1'b1; md[ix] = 1'b0; mt[ix] = a[7:5];
  endtask

  task automatic model_op(input bit we, input logic [7:0] a, input logic [7:0] wd,
                          output bit h, output logic [7:0] rd);
    logic [1:0] ix = a[4:3];
    h  = mv[ix] && (mt[ix] == a[7:5]);
    rd = 8'h00;
    if (!we) begin
      if (!h) model_evict_fill(a);
      rd = mc[a[4:0]];
    end else if (h || cfg_al) begin
      if (!h) model_evict_fill(a);
      mc[a[4:0]] = wd;
      if (cfg_wb) md[ix] = 1'b1;
      else        m_mem[a] = wd;
    end else begin
      m_mem[a] = wd;
    end
  endtask

  task automatic access(input bit we, input logic [7:0] a, input logic [7:0] wd);
    bit eh;
    logic [7:0] er;
    int waitc = 0, bad = 0, first = 0;
    bit fast;
    model_op(we, a, wd, eh, er);
    fast = eh && (!we || cfg_wb);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = we; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    if (fast) begin
      chk(rsp_valid == 1'b1, "R10 hit latency", int'(rsp_valid), 1);
    end else begin
      chk(!rsp_valid && !req_ready, "R9 busy during slow access",
          int'({rsp_valid, req_ready}), 0);
      while (!rsp_valid && waitc < 400) begin @(negedge clk); waitc++; end
    end
    chk(rsp_valid == 1'b1, "R10 response present", int'(rsp_valid), 1);
    chk(rsp_hit == eh, "R1 hit flag", int'(rsp_hit), int'(eh));
    if (!we) chk(rsp_rdata == er, "R2 read data", int'(rsp_rdata), int'(er));
    for (int i = 0; i < 256; i++)
      if (pmem[i] !== m_mem[i]) begin if (bad == 0) first = i; bad++; end
    chk(bad == 0, mem_req_tag(), int'(pmem[first]), int'(m_mem[first]));
    @(negedge clk);
    chk(!rsp_valid, "R10 single pulse", int'(rsp_valid), 0);
    exp_acc++;
    if (eh) exp_hits++;
  endtask

  task automatic do_flush();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    flush = 1'b1; req_valid = 1'b1; req_addr = 8'h00; req_write = 1'b0;
    #1;
    chk(!req_ready, "R7 flush blocks request", int'(req_ready), 0);
    @(negedge clk);
    flush = 1'b0; req_valid = 1'b0;
    for (int i = 0; i < 4; i++) begin mv[i] = 1'b0; md[i] = 1'b0; end
  endtask

  task automatic run_config(input bit wb, input bit al);
    cfg_wb = wb; cfg_al = al;
    do_flush();
    access(1'b0, 8'h00, 8'h00);   // R2 miss fill
    access(1'b0, 8'h07, 8'h00);   // R1 same block hits
    access(1'b1, 8'h01, 8'hA5);   // write hit (R3 / R4)
    access(1'b1, 8'h2A, 8'h5C);   // write miss (R5 / R6)
    access(1'b0, 8'h2A, 8'h00);
    access(1'b0, 8'h21, 8'h00);   // conflict with line 0: R3 eviction
    access(1'b0, 8'h01, 8'h00);
    do_flush();
    access(1'b0, 8'h01, 8'h00);   // R7 miss after flush
    for (int n = 0; n < 100; n++)
      access(1'($urandom % 2), {3'($urandom % 3), 5'($urandom)}, 8'($urandom));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) m_mem[i] = 8'(i * 7 + 3);
    for (int i = 0; i < 4; i++) begin mv[i] = 1'b0; md[i] = 1'b0; mt[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R11 ready after reset", int'(req_ready), 1);
    chk(!rsp_valid && !mem_valid, "R11 idle outputs", int'({rsp_valid, mem_valid}), 0);
    chk(stat_hits == 0 && stat_accesses == 0, "R11 counters cleared",
        int'(stat_accesses), 0);
    access(1'b0, 8'hE3, 8'h00);   // R11 cold miss
    run_config(1'b1, 1'b1);
    run_config(1'b0, 1'b1);
    run_config(1'b1, 1'b0);
    run_config(1'b0, 1'b0);
    chk(int'(stat_accesses) == exp_acc, "R8 access count", int'(stat_accesses), exp_acc);
    chk(int'(stat_hits) == exp_hits, "R8 hit count", int'(stat_hits), exp_hits);
    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule